// File: doc/BRIEF.md
# USB endpoint transfer handshake controller

This block holds the control bits and interrupt flags of one USB device endpoint and decides how the endpoint answers each token. Firmware sets and clears control bits through a pair of strobe vectors. It clears interrupt flags by writing ones. A packet engine reports decoded tokens, the end of a transmitted data packet, a received ACK handshake and the completion of received OUT data. One clock later the block presents its answer: a data packet, NAK, STALL, ACK or a zero-length DATA1 status packet.

On control endpoints the block follows the setup, data and status phases. A firmware-written direction bit selects the kind of status phase. A data-end bit tells the hardware that the last data packet is queued or consumed. While data-end is set, the remaining control bits are frozen for the current transfer. Force-stall applies to one transaction and is then reported back through a sticky flag. Isochronous endpoints release the transmit-ready bit when transmission ends, without waiting for an ACK.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset the control bits, the interrupt flags, the irq output and the phase are all 0, and resp_kind is 0 (no response).
- R2: Control bits are ctl_bits[3]=direction (1 = control read), [2]=data-end, [1]=force-stall, [0]=transmit-ready. A set strobe sets a bit on the next edge and a clear strobe clears it. When both strobes hit the same bit, clear wins.
- R3: Token codes are 1=IN, 2=OUT, 3=SETUP. Response codes are 0=none, 1=DATA, 2=NAK, 3=STALL, 4=zero-length DATA1, 5=ACK, registered one cycle after the token. An IN token is answered with the first response whose condition holds, checked in this order: STALL if force-stall is set; DATA if transmit-ready is set; zero-length DATA1 on a control endpoint (ep_type 0) with data-end=1 and direction=0; otherwise NAK. An OUT token gets STALL if force-stall is set, otherwise no response.
- R4: Sending a STALL clears force-stall and sets the stall-sent flag irq_flags[3], so the following token is answered as if no stall had been requested.
- R5: resp_data1 gives the PID of a data response. A SETUP makes the next data packet DATA1. Each ACKed data packet on a non-isochronous endpoint flips the PID. The value after reset is DATA0. Isochronous data (ep_type 1) is always DATA0, and the zero-length status packet is always DATA1.
- R6: On bulk (2), interrupt (3) and control endpoints, transmit-ready is cleared only by an ACK after a sent data packet. On isochronous endpoints it is cleared when transmission ends, and an ACK has no effect. Each such clear sets the transmit-done flag irq_flags[1].
- R7: Control read: an ACK of a data packet sent with data-end=1 and direction=1 moves the phase to status (2). The following OUT data completion is answered with ACK, sets the status-done flag irq_flags[2], returns the phase to idle (0) and leaves data-end set.
- R8: Control write: sending the zero-length DATA1 packet moves the phase to status. Its ACK sets the status-done flag and returns the phase to idle.
- R9: On a control endpoint with data-end set, firmware writes to direction, force-stall and transmit-ready have no effect.
- R10: A SETUP token is answered with ACK. It clears force-stall and data-end, sets the phase to data (1) and sets the setup flag irq_flags[0].
- R11: Interrupt flags are sticky until firmware writes 1 to them through fw_irq_ack. A hardware set in the same cycle wins. irq is high while any flag is set and its bit in irq_en is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_type | input | 2 | Endpoint kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| fw_set | input | 4 | Firmware strobes that set control bits |
| fw_clr | input | 4 | Firmware strobes that clear control bits |
| fw_irq_ack | input | 4 | Write-one-to-clear for interrupt flags |
| irq_en | input | 4 | Per-flag interrupt enable |
| tok_kind | input | 2 | Decoded token this cycle (0 none) |
| tx_end | input | 1 | Packet engine finished sending a data packet |
| ack_rx | input | 1 | ACK handshake received from the host |
| out_rx_done | input | 1 | OUT data packet received completely |
| resp_kind | output | 3 | Registered response code |
| resp_data1 | output | 1 | PID of the data response (1 = DATA1) |
| ctl_bits | output | 4 | Current control bits |
| irq_flags | output | 4 | Sticky interrupt flags |
| phase | output | 2 | Control transfer phase: 0 idle, 1 data, 2 status |
| irq | output | 1 | Processor interrupt request |

## Verification
The bench builds the block with its default package sizes: four control bits and four interrupt flags. This makes every control-bit setting reachable under every endpoint kind. For each of the 64 pairings it loads the bits in one write and replays IN and OUT tokens, which covers the full response priority and the one-shot stall. Directed sequences then run complete control-read and control-write transfers and the isochronous and bulk release of transmit-ready. They also exercise the data-end freeze and a flag acknowledge that collides with a hardware set.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  localparam int CTL_W    = 4;
  localparam int IRQ_W    = 4;
  localparam int CB_TXR   = 0;
  localparam int CB_STALL = 1;
  localparam int CB_DEND  = 2;
  localparam int CB_DIR   = 3;
  localparam int IF_SETUP  = 0;
  localparam int IF_TXDONE = 1;
  localparam int IF_STDONE = 2;
  localparam int IF_STSENT = 3;

  typedef enum logic [1:0] {EP_CTRL = 2'd0, EP_ISO = 2'd1, EP_BULK = 2'd2, EP_INTR = 2'd3} ep_kind_e;
  typedef enum logic [1:0] {TK_NONE = 2'd0, TK_IN = 2'd1, TK_OUT = 2'd2, TK_SETUP = 2'd3} tok_e;
  typedef enum logic [2:0] {RS_NONE = 3'd0, RS_DATA = 3'd1, RS_NAK = 3'd2, RS_STALL = 3'd3,
                            RS_ZLP1 = 3'd4, RS_ACK = 3'd5} resp_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_DATA = 2'd1, PH_STATUS = 2'd2} phase_e;
  typedef enum logic [1:0] {AW_NONE = 2'd0, AW_DATA = 2'd1, AW_ZLP = 2'd2} await_e;
endpackage

// File: rtl/ep_ctl_regs.sv
module ep_ctl_regs
  import ep_hs_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fw_set,
  input  logic [W-1:0] fw_clr,
  input  logic         is_ctrl,
  input  logic         setup_ev,
  input  logic         stall_used,
  input  logic         txr_hw_clr,
  output logic [W-1:0] ctl
);
  logic [W-1:0] q, d;
  logic         lock, ce;

  // firmware first, then hardware events override
  always_comb begin
    lock = is_ctrl & q[CB_DEND];
    d    = q;
    for (int i = 0; i < W; i++) begin
      if (i == CB_DEND || !lock) begin
        if (fw_set[i]) d[i] = 1'b1;
        if (fw_clr[i]) d[i] = 1'b0;
      end
    end
    if (stall_used) d[CB_STALL] = 1'b0;
    if (txr_hw_clr) d[CB_TXR]   = 1'b0;
    if (setup_ev) begin
      d[CB_STALL] = 1'b0;
      d[CB_DEND]  = 1'b0;
    end
  end

  assign ce = (|fw_set) | (|fw_clr) | stall_used | txr_hw_clr | setup_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= d;
  end

  assign ctl = q;
endmodule

// File: rtl/ep_token_responder.sv
module ep_token_responder
  import ep_hs_pkg::*;
(
  input  logic [1:0]       tok_kind,
  input  logic             is_ctrl,
  input  logic             is_iso,
  input  logic             toggle,
  input  logic [CTL_W-1:0] ctl,
  output resp_e            resp,
  output logic             data1,
  output logic             stall_used,
  output logic             send_data,
  output logic             send_zlp,
  output logic             setup_ev
);
  always_comb begin
    resp       = RS_NONE;
    data1      = 1'b0;
    stall_used = 1'b0;
    send_data  = 1'b0;
    send_zlp   = 1'b0;
    setup_ev   = 1'b0;
    case (tok_e'(tok_kind))
      TK_SETUP: begin
        resp     = RS_ACK;
        setup_ev = 1'b1;
      end
      TK_IN: begin
        if (ctl[CB_STALL]) begin
          resp       = RS_STALL;
          stall_used = 1'b1;
        end else if (ctl[CB_TXR]) begin
          resp      = RS_DATA;
          data1     = toggle & ~is_iso;
          send_data = 1'b1;
        end else if (is_ctrl && ctl[CB_DEND] && !ctl[CB_DIR]) begin
          resp     = RS_ZLP1;
          data1    = 1'b1;
          send_zlp = 1'b1;
        end else begin
          resp = RS_NAK;
        end
      end
      TK_OUT: begin
        if (ctl[CB_STALL]) begin
          resp       = RS_STALL;
          stall_used = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ep_xfer_tracker.sv
module ep_xfer_tracker
  import ep_hs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   is_ctrl,
  input  logic   is_iso,
  input  logic   dir_bit,
  input  logic   dend_bit,
  input  logic   setup_ev,
  input  logic   send_data,
  input  logic   send_zlp,
  input  logic   tx_end,
  input  logic   ack_rx,
  input  logic   out_rx_done,
  output logic   toggle,
  output phase_e phase,
  output logic   txr_hw_clr,
  output logic   status_done,
  output logic   out_ack
);
  phase_e ph_q, ph_d;
  await_e aw_q, aw_d;
  logic   tg_q, tg_d, ce;

  always_comb begin
    ph_d        = ph_q;
    aw_d        = aw_q;
    tg_d        = tg_q;
    txr_hw_clr  = 1'b0;
    status_done = 1'b0;
    out_ack     = out_rx_done;
    case (aw_q)
      AW_DATA: begin
        if (is_iso) begin
          if (tx_end) begin
            txr_hw_clr = 1'b1;
            aw_d       = AW_NONE;
          end
        end else if (ack_rx) begin
          txr_hw_clr = 1'b1;
          tg_d       = ~tg_q;
          aw_d       = AW_NONE;
          if (is_ctrl && dend_bit && dir_bit) ph_d = PH_STATUS;
        end
      end
      AW_ZLP: begin
        if (ack_rx) begin
          status_done = 1'b1;
          aw_d        = AW_NONE;
          ph_d        = PH_IDLE;
        end
      end
      default: ;
    endcase
    if (out_rx_done && is_ctrl && dir_bit && ph_q == PH_STATUS) begin
      status_done = 1'b1;
      ph_d        = PH_IDLE;
    end
    if (send_data) aw_d = AW_DATA;
    if (send_zlp) begin
      aw_d = AW_ZLP;
      ph_d = PH_STATUS;
    end
    if (setup_ev) begin
      tg_d = 1'b1;
      ph_d = PH_DATA;
      aw_d = AW_NONE;
    end
  end

  assign ce = (ph_d != ph_q) || (aw_d != aw_q) || (tg_d != tg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      aw_q <= AW_NONE;
      tg_q <= 1'b0;
    end else if (ce) begin
      ph_q <= ph_d;
      aw_q <= aw_d;
      tg_q <= tg_d;
    end
  end

  assign toggle = tg_q;
  assign phase  = ph_q;
endmodule

// File: rtl/ep_irq_flags.sv
module ep_irq_flags
  import ep_hs_pkg::*;
#(
  parameter int W = IRQ_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] fw_ack,
  input  logic [W-1:0] en,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] q, d;
  logic         ce;

  always_comb d = (q & ~fw_ack) | hw_set;
  assign ce = (|hw_set) | (|fw_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= d;
  end

  assign flags = q;
  assign irq   = |(q & en);
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import ep_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ep_type,
  input  logic [CTL_W-1:0] fw_set,
  input  logic [CTL_W-1:0] fw_clr,
  input  logic [IRQ_W-1:0] fw_irq_ack,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic [1:0]       tok_kind,
  input  logic             tx_end,
  input  logic             ack_rx,
  input  logic             out_rx_done,
  output logic [2:0]       resp_kind,
  output logic             resp_data1,
  output logic [CTL_W-1:0] ctl_bits,
  output logic [IRQ_W-1:0] irq_flags,
  output logic [1:0]       phase,
  output logic             irq
);
  logic             is_ctrl, is_iso;
  logic [CTL_W-1:0] ctl;
  logic             toggle, data1_nxt, stall_used, send_data, send_zlp, setup_ev;
  logic             txr_hw_clr, status_done, out_ack;
  resp_e            resp_nxt, resp_d, resp_q;
  logic             data1_q;
  phase_e           ph;
  logic [IRQ_W-1:0] flag_set;

  assign is_ctrl = (ep_kind_e'(ep_type) == EP_CTRL);
  assign is_iso  = (ep_kind_e'(ep_type) == EP_ISO);

  ep_token_responder u_resp (
    .tok_kind  (tok_kind),
    .is_ctrl   (is_ctrl),
    .is_iso    (is_iso),
    .toggle    (toggle),
    .ctl       (ctl),
    .resp      (resp_nxt),
    .data1     (data1_nxt),
    .stall_used(stall_used),
    .send_data (send_data),
    .send_zlp  (send_zlp),
    .setup_ev  (setup_ev)
  );

  ep_xfer_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_ctrl    (is_ctrl),
    .is_iso     (is_iso),
    .dir_bit    (ctl[CB_DIR]),
    .dend_bit   (ctl[CB_DEND]),
    .setup_ev   (setup_ev),
    .send_data  (send_data),
    .send_zlp   (send_zlp),
    .tx_end     (tx_end),
    .ack_rx     (ack_rx),
    .out_rx_done(out_rx_done),
    .toggle     (toggle),
    .phase      (ph),
    .txr_hw_clr (txr_hw_clr),
    .status_done(status_done),
    .out_ack    (out_ack)
  );

  ep_ctl_regs #(.W(CTL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fw_set    (fw_set),
    .fw_clr    (fw_clr),
    .is_ctrl   (is_ctrl),
    .setup_ev  (setup_ev),
    .stall_used(stall_used),
    .txr_hw_clr(txr_hw_clr),
    .ctl       (ctl)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[IF_SETUP]  = setup_ev;
    flag_set[IF_TXDONE] = txr_hw_clr;
    flag_set[IF_STDONE] = status_done;
    flag_set[IF_STSENT] = stall_used;
  end

  ep_irq_flags #(.W(IRQ_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .hw_set(flag_set),
    .fw_ack(fw_irq_ack),
    .en    (irq_en),
    .flags (irq_flags),
    .irq   (irq)
  );

  // token answer has priority over the ACK of finished OUT data
  always_comb resp_d = (resp_nxt == RS_NONE && out_ack) ? RS_ACK : resp_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q  <= RS_NONE;
      data1_q <= 1'b0;
    end else begin
      resp_q  <= resp_d;
      data1_q <= data1_nxt;
    end
  end

  assign resp_kind  = resp_q;
  assign resp_data1 = data1_q;
  assign ctl_bits   = ctl;
  assign phase      = ph;
endmodule

// File: rtl/usb_ep_handshake_chk.sv
module usb_ep_handshake_chk
  import ep_hs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ep_type,
  input logic [CTL_W-1:0] fw_set,
  input logic [CTL_W-1:0] fw_clr,
  input logic [IRQ_W-1:0] fw_irq_ack,
  input logic [1:0]       tok_kind,
  input logic             tx_end,
  input logic             ack_rx,
  input logic             out_rx_done,
  input logic [2:0]       resp_kind,
  input logic             resp_data1,
  input logic [CTL_W-1:0] ctl_bits,
  input logic [IRQ_W-1:0] irq_flags,
  input logic [1:0]       phase
);
  a_r4_stall_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    resp_kind == 3'd3 |-> (!ctl_bits[1] && irq_flags[3]));

  a_r5_zlp_is_data1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_kind == 3'd4 |-> resp_data1);

  a_r6_txr_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_type != 2'd1 && ctl_bits[0] && !ack_rx && !fw_clr[0]) |=> ctl_bits[0]);

  a_r9_dend_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_type == 2'd0 && ctl_bits[2] && tok_kind == 2'd0)
    |=> (ctl_bits[3] == $past(ctl_bits[3]) && ctl_bits[1] == $past(ctl_bits[1])));

  a_r10_setup_effect: assert property (@(posedge clk) disable iff (!rst_n)
    tok_kind == 2'd3 |=> (resp_kind == 3'd5 && !ctl_bits[1] && !ctl_bits[2]
                          && irq_flags[0] && phase == 2'd1));

  a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_flags) & ~$past(fw_irq_ack)) & ~irq_flags) == '0));

  a_r3_out_never_data: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_kind == 2'd2 && !out_rx_done && !tx_end) |=> (resp_kind == 3'd0 || resp_kind == 3'd3));
endmodule

bind usb_ep_handshake usb_ep_handshake_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ep_type    (ep_type),
  .fw_set     (fw_set),
  .fw_clr     (fw_clr),
  .fw_irq_ack (fw_irq_ack),
  .tok_kind   (tok_kind),
  .tx_end     (tx_end),
  .ack_rx     (ack_rx),
  .out_rx_done(out_rx_done),
  .resp_kind  (resp_kind),
  .resp_data1 (resp_data1),
  .ctl_bits   (ctl_bits),
  .irq_flags  (irq_flags),
  .phase      (phase)
);

// File: tb/usb_ep_handshake_bench.sv
`timescale 1ns/1ps
module usb_ep_handshake_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ep_type = 2'd0;
  logic [3:0] fw_set = '0, fw_clr = '0, fw_irq_ack = '0, irq_en = '0;
  logic [1:0] tok_kind = 2'd0;
  logic       tx_end = 1'b0, ack_rx = 1'b0, out_rx_done = 1'b0;
  logic [2:0] resp_kind;
  logic       resp_data1;
  logic [3:0] ctl_bits, irq_flags;
  logic [1:0] phase;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  usb_ep_handshake u_usb_ep_handshake (
    .clk(clk), .rst_n(rst_n), .ep_type(ep_type), .fw_set(fw_set), .fw_clr(fw_clr),
    .fw_irq_ack(fw_irq_ack), .irq_en(irq_en), .tok_kind(tok_kind), .tx_end(tx_end),
    .ack_rx(ack_rx), .out_rx_done(out_rx_done), .resp_kind(resp_kind),
    .resp_data1(resp_data1), .ctl_bits(ctl_bits), .irq_flags(irq_flags),
    .phase(phase), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all stimulus tasks start and end at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask
  task automatic fw(input logic [3:0] s, input logic [3:0] c);
    fw_set = s; fw_clr = c; @(negedge clk); fw_set = '0; fw_clr = '0;
  endtask
  task automatic tok(input logic [1:0] k);
    tok_kind = k; @(negedge clk); tok_kind = 2'd0;
  endtask
  task automatic host_ack();
    ack_rx = 1'b1; @(negedge clk); ack_rx = 1'b0;
  endtask
  task automatic send_end();
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
  endtask
  task automatic out_done();
    out_rx_done = 1'b1; @(negedge clk); out_rx_done = 1'b0;
  endtask
  task automatic flag_ack(input logic [3:0] m);
    fw_irq_ack = m; @(negedge clk); fw_irq_ack = '0;
  endtask

  function automatic int exp_in(input int k, input int b);
    if ((b & 2) != 0) return 3;
    if ((b & 1) != 0) return 1;
    if (k == 0 && (b & 4) != 0 && (b & 8) == 0) return 4;
    return 2;
  endfunction

  task automatic finish_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_up();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ctl", ctl_bits, 0);
    chk("R1 flags", irq_flags, 0);
    chk("R1 resp", resp_kind, 0);
    chk("R1 phase", phase, 0);
    chk("R1 irq", irq, 0);

    // R2/R3/R4/R5 sweep: every endpoint kind and control setting
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 16; b++) begin
        ep_type = 2'(k);
        do_reset();
        fw(4'(b), 4'd0);
        chk("R2 set", ctl_bits, b);
        tok(2'd1);
        chk("R3 IN answer", resp_kind, exp_in(k, b));
        if (exp_in(k, b) == 1) chk("R5 first data pid", resp_data1, 0);
        if (exp_in(k, b) == 4) chk("R5 zlp pid", resp_data1, 1);
        chk("R4 stall cleared", ctl_bits, b & ~2);
        chk("R4 stall flag", irq_flags[3], (b >> 1) & 1);
        tok(2'd1);
        chk("R4 next IN", resp_kind, exp_in(k, b & ~2));
        do_reset();
        fw(4'(b), 4'd0);
        tok(2'd2);
        chk("R3 OUT answer", resp_kind, ((b & 2) != 0) ? 3 : 0);
      end
    end

    // R2 clear wins over set
    ep_type = 2'd2;
    do_reset();
    fw(4'b0011, 4'b0001);
    chk("R2 clear wins", ctl_bits, 2);

    // R10 SETUP clears stall and data-end
    ep_type = 2'd0;
    do_reset();
    fw(4'b0110, 4'd0);
    tok(2'd3);
    chk("R10 resp", resp_kind, 5);
    chk("R10 ctl", ctl_bits, 0);
    chk("R10 phase", phase, 1);
    chk("R10 flag", irq_flags, 1);

    // R7 control read transfer
    do_reset();
    tok(2'd3);
    fw(4'b1001, 4'd0);
    tok(2'd1);
    chk("R5 after setup", resp_data1, 1);
    chk("R3 ctrl data", resp_kind, 1);
    host_ack();
    chk("R6 ack clears", ctl_bits, 8);
    chk("R6 txdone flag", irq_flags[1], 1);
    chk("R7 still data", phase, 1);
    fw(4'b0101, 4'd0);
    chk("R2 ctl", ctl_bits, 13);
    tok(2'd1);
    chk("R5 toggled", resp_data1, 0);
    host_ack();
    chk("R7 status phase", phase, 2);
    chk("R7 ctl", ctl_bits, 12);
    out_done();
    chk("R7 ack", resp_kind, 5);
    chk("R7 idle", phase, 0);
    chk("R7 stdone", irq_flags[2], 1);
    chk("R7 dend kept", ctl_bits, 12);

    // R9 data-end freeze
    fw(4'b0011, 4'b1000);
    chk("R9 writes ignored", ctl_bits, 12);
    tok(2'd1);
    chk("R9 no stall no data", resp_kind, 2);

    // R11 enables and write-one-to-clear
    chk("R11 flags", irq_flags, 7);
    irq_en = 4'b0000; #1;
    chk("R11 irq masked", irq, 0);
    irq_en = 4'b0100; #1;
    chk("R11 irq raised", irq, 1);
    flag_ack(4'b0100);
    chk("R11 cleared", irq_flags, 3);
    chk("R11 irq low", irq, 0);
    irq_en = 4'b0000;
    tok_kind = 2'd3; fw_irq_ack = 4'b0001;
    @(negedge clk);
    tok_kind = 2'd0; fw_irq_ack = 4'd0;
    chk("R11 set wins", irq_flags[0], 1);

    // R8 control write
    fw(4'd0, 4'b1000);
    fw(4'b0100, 4'd0);
    flag_ack(4'b1111);
    tok(2'd1);
    chk("R8 zlp", resp_kind, 4);
    chk("R8 status", phase, 2);
    host_ack();
    chk("R8 idle", phase, 0);
    chk("R8 stdone", irq_flags, 4);

    // R6 isochronous release
    ep_type = 2'd1;
    do_reset();
    fw(4'b0001, 4'd0);
    tok(2'd1);
    chk("R5 iso pid", resp_data1, 0);
    host_ack();
    chk("R6 iso ack ignored", ctl_bits, 1);
    send_end();
    chk("R6 iso cleared", ctl_bits, 0);
    chk("R6 iso flag", irq_flags[1], 1);

    // R6/R5 bulk
    ep_type = 2'd2;
    do_reset();
    fw(4'b0001, 4'd0);
    tok(2'd1);
    send_end();
    chk("R6 bulk end kept", ctl_bits, 1);
    host_ack();
    chk("R6 bulk ack", ctl_bits, 0);
    fw(4'b0001, 4'd0);
    tok(2'd1);
    chk("R5 bulk flip", resp_data1, 1);

    finish_up();
  end
endmodule